// File: doc/BRIEF.md
# UART Automatic Hardware Flow Controller

This block performs automatic RTS/CTS handshaking for a UART whose receive and transmit buffers are 16 characters deep. On the receive side it decides when to tell the far end to pause by driving the active-low request-to-send output. It bases that decision on how full the receive buffer is, on the selected receive trigger level, and on a strobe from the receiver that marks the first data bit of an incoming character. On the transmit side it produces a start permit for the serialiser. The permit comes from the active-low clear-to-send input. That input is synchronised first, and it is only allowed to stop the transmitter at the middle of the last stop bit of the character being sent.

Two modem-control bits choose the mode. With the flow enable clear, RTS follows the software RTS bit and the transmitter is never held. With the flow enable set, automatic CTS gating is on. If the RTS bit is also set, automatic RTS is on as well. The block also flags changes of the synchronised CTS level for the modem-status interrupt logic, and it suppresses those flags while automatic CTS is on. The serialisers, the buffers and the interrupt logic sit outside this block.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `rtsN` is 1 and `ctsChangeEvt` is 0, and with `flowEn`=0 `txPermit` is 1.
- R2: When automatic RTS is off (`flowEn`=0 or `rtsBit`=0), `rtsN` takes the inverse of `rtsBit` one clock later, and with `flowEn`=0 `txPermit` stays 1 whatever `ctsN` does.
- R3: Automatic RTS is on exactly when `flowEn`=1 and `rtsBit`=1; with `flowEn`=1 and `rtsBit`=0 only CTS gating is active and `rtsN` stays 1.
- R4: `trigSel` encodes the receive trigger as 0→1, 1→4, 2→8, 3→14 characters. For codes 0–2 under automatic RTS, `rtsN` goes to 1 one clock after `rxCount` is at or above the trigger.
- R5: For codes 0–2 under automatic RTS, once `rtsN` is 1 it stays 1 until `rxCount` is 0, and it returns to 0 one clock after that.
- R6: For code 3 under automatic RTS, `rtsN` goes to 1 one clock after `rxFirstBit` pulses while `rxCount` is 15, and it is 1 whenever `rxCount` is 16.
- R7: For code 3 under automatic RTS, `rtsN` is 0 one clock after `rxCount` is 15 or less, unless the 16th character has started and not yet landed. That state ends when `rxCount` leaves 15.
- R8: With `flowEn`=1 and `txPermit`=1, `txPermit` falls only one clock after a `txStopMid` pulse that sees CTS inactive (synchronised `ctsN`=1). Without the pulse it stays 1.
- R9: With `flowEn`=1 and `txPermit`=0, `txPermit` rises once the synchronised CTS is active. That happens three clocks after `ctsN` goes to 0: two synchroniser flops, then the gate register.
- R10: `ctsChangeEvt` pulses for one clock two clocks after each `ctsN` change while `flowEn`=0, and it stays 0 while `flowEn`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| flowEn | input | 1 | Flow-control enable bit from modem control |
| rtsBit | input | 1 | Software RTS bit from modem control |
| rxCount | input | 5 | Receive buffer fill count, 0 to 16 |
| trigSel | input | 2 | Receive trigger code |
| rxFirstBit | input | 1 | Pulse: first data bit of a new character is on the line |
| txStopMid | input | 1 | Pulse: middle of the last stop bit of the outgoing character |
| ctsN | input | 1 | Clear-to-send, active low, asynchronous |
| rtsN | output | 1 | Request-to-send, active low |
| txPermit | output | 1 | Transmitter may start a new character |
| ctsChangeEvt | output | 1 | Synchronised CTS changed (for the modem-status interrupt) |

## Verification
Directed sequences drive the fill count up through each trigger and back down. These show whether the low-trigger hysteresis (hold until empty) and the near-full rule for code 3 (release on the 16th start, resume at one free slot) are kept apart. A read during the 16th character shows whether that in-flight release is withdrawn. CTS toggles with and without the stop-bit pulse show whether a running transmitter is stopped only at a character boundary and whether a blocked one resumes after the synchroniser. Seeded random runs mix modes, counts, strobes and CTS edges against a bench model, to catch slips in mode changes and at the boundaries.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
  // Decisions handed from control to datapath each cycle
  typedef struct packed {
    logic rtsNext;
    logic pendNext;
    logic gateKeep;
    logic evtMask;
    logic permitOpen;
  } flowCtl_t;

  // Registered state handed back from datapath to control
  typedef struct packed {
    logic rtsN;
    logic pend;
    logic gate;
    logic ctsActive;
  } flowState_t;
endpackage

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import uart_flow_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             flowEn,
  input  logic             rtsBit,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [1:0]       trigSel,
  input  logic             rxFirstBit,
  input  logic             txStopMid,
  input  flowState_t       st,
  output flowCtl_t         ctl
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEPTH - 1);

  logic             autoRts;
  logic             nearFullMode;
  logic [CNT_W-1:0] trigLevel;
  logic             isFull;
  logic             isLast;
  logic             lowRelease;
  logic             topRelease;

  always_comb begin
    case (trigSel)
      2'd0:    trigLevel = CNT_W'(TRIG_0);
      2'd1:    trigLevel = CNT_W'(TRIG_1);
      default: trigLevel = CNT_W'(TRIG_2);
    endcase
  end

  assign autoRts      = flowEn & rtsBit;
  assign nearFullMode = (trigSel == 2'd3);
  assign isFull       = (rxCount == FULL_CNT);
  assign isLast       = (rxCount == LAST_CNT);

  // Low triggers: release at trigger, hold until drained
  assign lowRelease = st.rtsN ? (rxCount != '0) : (rxCount >= trigLevel);
  // Top trigger: release while full or while last character is arriving
  assign topRelease = isFull | (isLast & (st.pend | rxFirstBit));

  always_comb begin
    ctl = '0;
    ctl.pendNext   = autoRts & nearFullMode & isLast & (st.pend | rxFirstBit);
    if (!autoRts)          ctl.rtsNext = ~rtsBit;
    else if (nearFullMode) ctl.rtsNext = topRelease;
    else                   ctl.rtsNext = lowRelease;
    ctl.gateKeep   = st.gate & ~txStopMid;
    ctl.evtMask    = flowEn;
    ctl.permitOpen = ~flowEn;
  end
endmodule

// File: rtl/uart_flow_dp.sv
module uart_flow_dp
  import uart_flow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctsN,
  input  flowCtl_t   ctl,
  output flowState_t st,
  output logic       rtsN,
  output logic       txPermit,
  output logic       ctsChangeEvt
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   ctsDly;
  logic                   rtsQ;
  logic                   pendQ;
  logic                   gateQ;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncQ[0] <= 1'b1;
          else     syncQ[0] <= ctsN;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) syncQ[i] <= 1'b1;
          else     syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctsDly <= 1'b1;
      rtsQ   <= 1'b1;
      pendQ  <= 1'b0;
      gateQ  <= 1'b0;
    end else begin
      ctsDly <= syncQ[SYNC_STAGES-1];
      rtsQ   <= ctl.rtsNext;
      pendQ  <= ctl.pendNext;
      gateQ  <= ctl.gateKeep ? 1'b1 : ~syncQ[SYNC_STAGES-1];
    end
  end

  assign st.rtsN      = rtsQ;
  assign st.pend      = pendQ;
  assign st.gate      = gateQ;
  assign st.ctsActive = ~syncQ[SYNC_STAGES-1];

  assign rtsN         = rtsQ;
  assign txPermit     = ctl.permitOpen | gateQ;
  assign ctsChangeEvt = (syncQ[SYNC_STAGES-1] ^ ctsDly) & ~ctl.evtMask;
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uart_flow_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flowEn,
  input  logic             rtsBit,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [1:0]       trigSel,
  input  logic             rxFirstBit,
  input  logic             txStopMid,
  input  logic             ctsN,
  output logic             rtsN,
  output logic             txPermit,
  output logic             ctsChangeEvt
);
  flowCtl_t   ctl;
  flowState_t st;

  uart_flow_ctl #(.DEPTH(DEPTH)) u_ctl (
    .flowEn     (flowEn),
    .rtsBit     (rtsBit),
    .rxCount    (rxCount),
    .trigSel    (trigSel),
    .rxFirstBit (rxFirstBit),
    .txStopMid  (txStopMid),
    .st         (st),
    .ctl        (ctl)
  );

  uart_flow_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .ctsN         (ctsN),
    .ctl          (ctl),
    .st           (st),
    .rtsN         (rtsN),
    .txPermit     (txPermit),
    .ctsChangeEvt (ctsChangeEvt)
  );
endmodule

// File: rtl/uart_flow_chk.sv
module uart_flow_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             flowEn,
  input logic             rtsBit,
  input logic [CNT_W-1:0] rxCount,
  input logic [1:0]       trigSel,
  input logic             txStopMid,
  input logic             rtsN,
  input logic             txPermit,
  input logic             ctsChangeEvt
);
  // R2: manual RTS follows the software bit
  a_r2_manual_rts: assert property (@(posedge clk) disable iff (rst)
    !(flowEn && rtsBit) |=> (rtsN == !$past(rtsBit)));

  // R4: lowest trigger releases with any stored character
  a_r4_low_trigger: assert property (@(posedge clk) disable iff (rst)
    (flowEn && rtsBit && trigSel == 2'd0 && rxCount != '0) |=> rtsN);

  // R5: low triggers hold release until the buffer is drained
  a_r5_hold_until_empty: assert property (@(posedge clk) disable iff (rst)
    (flowEn && rtsBit && trigSel != 2'd3 && rtsN && rxCount != '0) |=> rtsN);

  // R6: top trigger releases when the buffer is full
  a_r6_full_release: assert property (@(posedge clk) disable iff (rst)
    (flowEn && rtsBit && trigSel == 2'd3 && rxCount == CNT_W'(16)) |=> rtsN);

  // R8: permit drops only after a stop-bit pulse
  a_r8_drop_at_stop: assert property (@(posedge clk) disable iff (rst)
    (flowEn && txPermit && !txStopMid) |=> txPermit);

  // R10: no CTS change events while automatic CTS is active
  a_r10_quiet_in_auto: assert property (@(posedge clk) disable iff (rst)
    flowEn |-> !ctsChangeEvt);
endmodule

bind uart_flow_ctrl uart_flow_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .flowEn       (flowEn),
  .rtsBit       (rtsBit),
  .rxCount      (rxCount),
  .trigSel      (trigSel),
  .txStopMid    (txStopMid),
  .rtsN         (rtsN),
  .txPermit     (txPermit),
  .ctsChangeEvt (ctsChangeEvt)
);

// File: tb/tb_uart_flow_ctrl.sv
module tb_uart_flow_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       flowEn, rtsBit, rxFirstBit, txStopMid, ctsN;
  logic [4:0] rxCount;
  logic [1:0] trigSel;
  logic       rtsN, txPermit, ctsChangeEvt;

  int nChecks = 0;
  int nFails  = 0;

  // bench model state
  logic [1:0] mSync;
  logic       mDly, mRts, mPend, mGate;

  always #5 clk = ~clk;

  uart_flow_ctrl dut (
    .clk(clk), .rst(rst), .flowEn(flowEn), .rtsBit(rtsBit),
    .rxCount(rxCount), .trigSel(trigSel), .rxFirstBit(rxFirstBit),
    .txStopMid(txStopMid), .ctsN(ctsN), .rtsN(rtsN),
    .txPermit(txPermit), .ctsChangeEvt(ctsChangeEvt)
  );

  function automatic int trigOf(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic modelRts();
    if (!(flowEn && rtsBit)) return !rtsBit;
    if (trigSel == 2'd3)
      return (rxCount == 16) || (rxCount == 15 && (mPend || rxFirstBit));
    if (mRts) return rxCount != 0;
    return int'(rxCount) >= trigOf(trigSel);
  endfunction

  task automatic modelStep();
    logic nr, np, ng;
    nr = modelRts();
    np = flowEn && rtsBit && trigSel == 2'd3 && rxCount == 15 && (mPend || rxFirstBit);
    ng = (mGate && !txStopMid) ? 1'b1 : !mSync[1];
    mDly  = mSync[1];
    mSync = {mSync[0], ctsN};
    mRts  = nr;
    mPend = np;
    mGate = ng;
  endtask

  task automatic modelReset();
    mSync = 2'b11; mDly = 1'b1; mRts = 1'b1; mPend = 1'b0; mGate = 1'b0;
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven; update model at edge, compare at negedge
  task automatic step(input string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check({tag, " rtsN"}, rtsN, mRts);
    check({tag, " txPermit"}, txPermit, flowEn ? mGate : 1'b1);
    check({tag, " ctsChangeEvt"}, ctsChangeEvt, (mSync[1] ^ mDly) & !flowEn);
    rxFirstBit = 1'b0;
    txStopMid  = 1'b0;
  endtask

  task automatic finish();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'd1234));
    flowEn = 0; rtsBit = 0; rxCount = 0; trigSel = 0;
    rxFirstBit = 0; txStopMid = 0; ctsN = 1; rst = 1;
    modelReset();
    repeat (3) @(negedge clk);
    check("R1 reset rtsN", rtsN, 1'b1);
    check("R1 reset evt", ctsChangeEvt, 1'b0);
    check("R1 reset permit", txPermit, 1'b1);
    rst = 0;
    step("R1 first cycle");
    check("R1 post reset rtsN", rtsN, 1'b1);

    // R2: manual RTS and open permit
    rtsBit = 1; step("R2 manual");
    check("R2 rts follows bit", rtsN, 1'b0);
    ctsN = 1; step("R2"); ctsN = 0; step("R2"); step("R2");
    check("R2 permit open", txPermit, 1'b1);
    rtsBit = 0; step("R2 manual off");
    check("R2 rts released", rtsN, 1'b1);

    // R3: auto CTS only
    flowEn = 1; rtsBit = 0; rxCount = 16; step("R3"); step("R3");
    check("R3 cts-only rtsN", rtsN, 1'b1);

    // R4/R5: trigger 4 hysteresis
    rtsBit = 1; trigSel = 1; rxCount = 0; step("R5 drain"); step("R5");
    check("R5 asserted when empty", rtsN, 1'b0);
    for (int c = 1; c <= 5; c++) begin
      rxCount = 5'(c); step("R4 fill");
      check("R4 trigger 4", rtsN, c >= 4);
    end
    for (int c = 4; c >= 0; c--) begin
      rxCount = 5'(c); step("R5 drain");
      check("R5 hold until empty", rtsN, c != 0);
    end

    // R6/R7: near-full rule
    trigSel = 3; rxCount = 14; step("R7");
    check("R7 room left", rtsN, 1'b0);
    rxCount = 15; step("R7"); check("R7 one free slot", rtsN, 1'b0);
    rxFirstBit = 1; step("R6 16th start");
    check("R6 release on 16th start", rtsN, 1'b1);
    step("R6 in flight"); check("R6 held while arriving", rtsN, 1'b1);
    rxCount = 16; step("R6 full"); check("R6 full", rtsN, 1'b1);
    rxCount = 15; step("R7 read"); check("R7 reassert one free", rtsN, 1'b0);
    rxFirstBit = 1; step("R6"); rxCount = 14; step("R7 read in flight");
    check("R7 withdrawn release", rtsN, 1'b0);

    // R8/R9: CTS gating
    ctsN = 0; step("R9"); step("R9"); step("R9");
    check("R9 resume after sync", txPermit, 1'b1);
    ctsN = 1; repeat (4) step("R8 no pulse");
    check("R8 held without pulse", txPermit, 1'b1);
    txStopMid = 1; step("R8 stop mid");
    check("R8 drop at stop", txPermit, 1'b0);
    ctsN = 0; step("R9"); step("R9");
    check("R9 still blocked in sync", txPermit, 1'b0);
    step("R9"); check("R9 resumed", txPermit, 1'b1);

    // R10: change events
    ctsN = 1; step("R10"); step("R10");
    check("R10 quiet in auto", ctsChangeEvt, 1'b0);
    flowEn = 0; step("R10"); ctsN = 0; step("R10"); step("R10");
    check("R10 event pulse", ctsChangeEvt, 1'b1);
    step("R10"); check("R10 single pulse", ctsChangeEvt, 1'b0);

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      if (n % 50 == 0) begin
        flowEn = 1'($urandom);
        rtsBit = 1'($urandom);
        trigSel = 2'($urandom);
      end
      if ($urandom % 4 == 0) rxCount = 5'($urandom % 17);
      rxFirstBit = ($urandom % 6 == 0);
      txStopMid  = ($urandom % 6 == 0);
      if ($urandom % 8 == 0) ctsN = ~ctsN;
      step("random R2..R10");
    end
    finish();
  end
endmodule